// File: doc/BRIEF.md
# Pinned Translation Insert Unit

This block holds a small address-translation store for one processor pipeline. Each of the two sides, instruction fetch and data access, has eight pinned slots and sixteen cached slots. A single-cycle insert command writes a new translation into a chosen pinned slot. The command carries a side bit, a slot index, a physical address word, a page-size code, a protection key and a 64-bit virtual address. It also carries the interruption-collection bit, the current privilege level, the virtual-mode bit and two operand poison flags. The block first resolves faults by a fixed priority, and a command with any fault changes nothing. A clean insert removes every cached entry that overlaps the new page and then writes the slot.

The three top bits of every virtual address pick one of eight region identifiers. These come in on a flat input bus, with region i at bits [24*i+23 : 24*i]. The identifier is stored with the entry and compared on every overlap test and every lookup. The translation that a new insert pushes out of its pinned slot can live on as a cached entry, placed by a per-side rotating pointer. A combinational lookup port returns the hit flag, the physical address and the key for a side and an address.

Top module: `xlat_pin_unit`

## Requirements
- R1: The slot index is the 8-bit `cmd_slot`. Values 0 to 7 are accepted. Any value of 8 or above raises fault code 4.
- R2: `rsp_fault` reports only the highest-priority fault, in this order:
  - 1 when `cmd_ic` is set.
  - 2 when `cmd_cpl` is nonzero.
  - 3 when either poison flag is set.
  - 4 for a bad slot.
  - 5 for an unsupported page-size code, or a physical word with any bit at position 50 or above set.
  - 6 when any virtual address bit in positions 60..51 is set.
  - 7 when `cmd_vm` is set.
  - 0 when there is no fault.
- R3: A faulting command performs no purge and no write. Every lookup result stays as it was.
- R4: The region identifier of an entry is taken from `rgn_ids` at the time of insert, selected by virtual address bits 63:61. A lookup hits only when the identifier selected by its own address bits 63:61 is equal to the stored one.
- R5: On insert, the virtual address and the physical word are both aligned down to the page size. A hit returns the aligned physical base plus the lookup address's offset within the page.
- R6: A page-size code gives log2 of the page size in bytes. The legal codes are 12, 14, 16, 18, 20, 22, 24 and 26. A legal entry covers exactly 2^code bytes from its aligned base.
- R7: A clean insert invalidates every same-side cached entry whose region identifier matches and whose range intersects the new page. The test masks the addresses at the larger of the two page sizes.
- R8: With `CROSS_PURGE`=1, a clean insert applies the same overlap purge to the other side's cached entries. With `CROSS_PURGE`=0, the other side is left untouched.
- R9: A valid translation displaced from a pinned slot is written into the same side's cached slot at the rotating pointer, and the pointer advances. The pointer wraps after 16 slots and overwrites the oldest placement.
- R10: A displaced translation that overlaps the new one is dropped. It takes no cached slot and does not advance the pointer.
- R11: On lookup, any pinned hit wins over any cached hit. Within one kind, the lowest index wins. On a miss, `lk_hit`, `lk_pa` and `lk_key` are all zero.
- R12: After reset, every entry is invalid, both pointers are zero and `rsp_valid` is 0.
- R13: `rsp_valid` is 1 in exactly the cycle after a cycle with `cmd_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Insert command present this cycle |
| cmd_side | input | 1 | 0 instruction side, 1 data side |
| cmd_slot | input | 8 | Pinned slot index |
| cmd_phys | input | 64 | Physical address word |
| cmd_ps | input | 6 | Page-size code (log2 bytes) |
| cmd_key | input | 24 | Protection key |
| cmd_va | input | 64 | Virtual address, bits 63:61 pick the region |
| cmd_ic | input | 1 | Interruption collection enabled |
| cmd_cpl | input | 2 | Current privilege level |
| cmd_vm | input | 1 | Virtual-mode status bit |
| cmd_nat_slot | input | 1 | Slot operand is poisoned |
| cmd_nat_phys | input | 1 | Physical operand is poisoned |
| rgn_ids | input | 192 | Eight 24-bit region identifiers |
| rsp_valid | output | 1 | Fault result valid |
| rsp_fault | output | 3 | Fault code of the previous command |
| lk_side | input | 1 | Lookup side |
| lk_addr | input | 64 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | 64 | Translated physical address |
| lk_key | output | 24 | Key of the hitting entry |

## Verification
Fault resolution is swept over all 128 combinations of the seven fault causes. Each combination's code is compared with the lowest set cause, and a lookup afterwards shows whether anything was written. Every 6-bit page-size code is inserted and probed at the last byte inside the page and the first byte past it, which separates legal codes from illegal ones and exposes off-by-one sizing. Purges are tried with a small page inside a large one, a large page over a small one, and an adjacent page that must survive, on the same side and across sides in two configurations. Displacement chains of 18 inserts, and pages that overlap their own predecessor, separate rotating placement from dropping.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int VPART_W = 61;
    localparam int RID_W   = 24;
    localparam int KEY_W   = 24;
    localparam int PS_W    = 6;
    localparam int N_RGN   = 8;
    localparam int PS_MIN  = 12;
    localparam int PS_MAX  = 26;

    typedef enum logic [2:0] {
        F_NONE     = 3'd0,
        F_ILLEGAL  = 3'd1,
        F_PRIV     = 3'd2,
        F_NAT      = 3'd3,
        F_RSVD_REG = 3'd4,
        F_RSVD_FLD = 3'd5,
        F_UNIMPL   = 3'd6,
        F_VIRT     = 3'd7
    } fault_e;

    typedef struct packed {
        logic               vld;
        logic [RID_W-1:0]   rid;
        logic [VPART_W-1:0] va;
        logic [PS_W-1:0]    ps;
        logic [63:0]        pa;
        logic [KEY_W-1:0]   key;
    } xent_t;

    function automatic logic [VPART_W-1:0] page_mask(input logic [PS_W-1:0] ps);
        return ~((VPART_W'(1) << ps) - VPART_W'(1));
    endfunction

    function automatic logic [63:0] page_mask64(input logic [PS_W-1:0] ps);
        return ~((64'd1 << ps) - 64'd1);
    endfunction

    function automatic logic ps_legal(input logic [PS_W-1:0] ps);
        return (ps >= PS_W'(PS_MIN)) && (ps <= PS_W'(PS_MAX)) && !ps[0];
    endfunction

    // Region match plus range intersection, masked at the larger page.
    function automatic logic ents_overlap(input xent_t e, input logic [RID_W-1:0] rid,
                                          input logic [VPART_W-1:0] va,
                                          input logic [PS_W-1:0] ps);
        logic [PS_W-1:0] big;
        big = (e.ps > ps) ? e.ps : ps;
        return e.vld && (e.rid == rid) && (((e.va ^ va) & page_mask(big)) == '0);
    endfunction
endpackage

// File: rtl/xlat_fault_chk.sv
module xlat_fault_chk
    import xlat_pkg::*;
#(
    parameter int NUM_TR  = 8,
    parameter int PA_W    = 50,
    parameter int IMPL_VA = 51
) (
    input  logic               ic,
    input  logic [1:0]         cpl,
    input  logic               nat_a,
    input  logic               nat_b,
    input  logic [7:0]         slot,
    input  logic [PS_W-1:0]    ps,
    input  logic [63:0]        phys,
    input  logic [VPART_W-1:0] va,
    input  logic               vm,
    output fault_e             fault
);
    logic phys_rsvd;
    logic va_unimpl;

    always_comb begin
        phys_rsvd = (phys >> PA_W) != 64'd0;
        va_unimpl = (va >> IMPL_VA) != '0;
        if (ic)                             fault = F_ILLEGAL;
        else if (cpl != 2'd0)               fault = F_PRIV;
        else if (nat_a || nat_b)            fault = F_NAT;
        else if (slot >= 8'(NUM_TR))        fault = F_RSVD_REG;
        else if (!ps_legal(ps) || phys_rsvd) fault = F_RSVD_FLD;
        else if (va_unimpl)                 fault = F_UNIMPL;
        else if (vm)                        fault = F_VIRT;
        else                                fault = F_NONE;
    end
endmodule

// File: rtl/xlat_overlap_vec.sv
module xlat_overlap_vec
    import xlat_pkg::*;
#(
    parameter int N = 16
) (
    input  xent_t [N-1:0]      ents,
    input  logic [RID_W-1:0]   rid,
    input  logic [VPART_W-1:0] va,
    input  logic [PS_W-1:0]    ps,
    output logic [N-1:0]       hit
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit[i] = ents_overlap(ents[i], rid, va, ps);
    end
endmodule

// File: rtl/xlat_pin_unit.sv
module xlat_pin_unit
    import xlat_pkg::*;
#(
    parameter int NUM_TR      = 8,
    parameter int NUM_TC      = 16,
    parameter int PA_W        = 50,
    parameter int IMPL_VA     = 51,
    parameter bit CROSS_PURGE = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_valid,
    input  logic                   cmd_side,
    input  logic [7:0]             cmd_slot,
    input  logic [63:0]            cmd_phys,
    input  logic [PS_W-1:0]        cmd_ps,
    input  logic [KEY_W-1:0]       cmd_key,
    input  logic [63:0]            cmd_va,
    input  logic                   cmd_ic,
    input  logic [1:0]             cmd_cpl,
    input  logic                   cmd_vm,
    input  logic                   cmd_nat_slot,
    input  logic                   cmd_nat_phys,
    input  logic [N_RGN*RID_W-1:0] rgn_ids,
    output logic                   rsp_valid,
    output logic [2:0]             rsp_fault,
    input  logic                   lk_side,
    input  logic [63:0]            lk_addr,
    output logic                   lk_hit,
    output logic [63:0]            lk_pa,
    output logic [KEY_W-1:0]       lk_key
);
    localparam int TR_IW = $clog2(NUM_TR);
    localparam int PTR_W = $clog2(NUM_TC);

    typedef struct packed {
        xent_t [1:0][NUM_TR-1:0] tr;
        xent_t [1:0][NUM_TC-1:0] tc;
        logic  [1:0][PTR_W-1:0]  ptr;
        logic                    rsp_vld;
        fault_e                  fault;
    } st_t;

    st_t st_d, st_q;

    // Command decode
    logic [RID_W-1:0]   new_rid;
    logic [VPART_W-1:0] new_va;
    xent_t              new_ent;
    xent_t              old_ent;
    logic [TR_IW-1:0]   slot_i;
    fault_e             cur_fault;
    logic [1:0][NUM_TC-1:0] purge_hit;

    always_comb begin
        new_rid     = rgn_ids[cmd_va[63:61]*RID_W +: RID_W];
        new_va      = cmd_va[60:0] & page_mask(cmd_ps);
        slot_i      = cmd_slot[TR_IW-1:0];
        new_ent.vld = 1'b1;
        new_ent.rid = new_rid;
        new_ent.va  = new_va;
        new_ent.ps  = cmd_ps;
        new_ent.pa  = cmd_phys & page_mask64(cmd_ps);
        new_ent.key = cmd_key;
        old_ent     = st_q.tr[cmd_side][slot_i];
    end

    xlat_fault_chk #(
        .NUM_TR  (NUM_TR),
        .PA_W    (PA_W),
        .IMPL_VA (IMPL_VA)
    ) u_fault (
        .ic    (cmd_ic),
        .cpl   (cmd_cpl),
        .nat_a (cmd_nat_slot),
        .nat_b (cmd_nat_phys),
        .slot  (cmd_slot),
        .ps    (cmd_ps),
        .phys  (cmd_phys),
        .va    (cmd_va[60:0]),
        .vm    (cmd_vm),
        .fault (cur_fault)
    );

    for (genvar s = 0; s < 2; s++) begin : g_side
        xlat_overlap_vec #(.N(NUM_TC)) u_purge (
            .ents (st_q.tc[s]),
            .rid  (new_rid),
            .va   (new_va),
            .ps   (cmd_ps),
            .hit  (purge_hit[s])
        );
    end

    // Next state
    always_comb begin
        st_d         = st_q;
        st_d.rsp_vld = cmd_valid;
        st_d.fault   = cmd_valid ? cur_fault : F_NONE;
        if (cmd_valid && (cur_fault == F_NONE)) begin
            for (int s = 0; s < 2; s++) begin
                if ((s == int'(cmd_side)) || CROSS_PURGE) begin
                    for (int i = 0; i < NUM_TC; i++) begin
                        if (purge_hit[s][i]) st_d.tc[s][i].vld = 1'b0;
                    end
                end
            end
            if (old_ent.vld && !ents_overlap(old_ent, new_rid, new_va, cmd_ps)) begin
                st_d.tc[cmd_side][st_q.ptr[cmd_side]] = old_ent;
                st_d.ptr[cmd_side] = (st_q.ptr[cmd_side] == PTR_W'(NUM_TC - 1))
                                     ? '0 : st_q.ptr[cmd_side] + 1'b1;
            end
            st_d.tr[cmd_side][slot_i] = new_ent;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_vld;
    assign rsp_fault = st_q.fault;

    // Lookup: a 4 KB probe overlaps an entry exactly when the address lies inside it
    logic [RID_W-1:0]        lk_rid;
    logic [VPART_W-1:0]      lk_va;
    xent_t [NUM_TR-1:0]      lk_tr_ents;
    xent_t [NUM_TC-1:0]      lk_tc_ents;
    logic  [NUM_TR-1:0]      lk_tr_hit;
    logic  [NUM_TC-1:0]      lk_tc_hit;
    xent_t                   lk_sel;

    always_comb begin
        lk_rid     = rgn_ids[lk_addr[63:61]*RID_W +: RID_W];
        lk_va      = lk_addr[60:0] & page_mask(PS_W'(PS_MIN));
        lk_tr_ents = st_q.tr[lk_side];
        lk_tc_ents = st_q.tc[lk_side];
    end

    xlat_overlap_vec #(.N(NUM_TR)) u_lk_tr (
        .ents (lk_tr_ents),
        .rid  (lk_rid),
        .va   (lk_va),
        .ps   (PS_W'(PS_MIN)),
        .hit  (lk_tr_hit)
    );

    xlat_overlap_vec #(.N(NUM_TC)) u_lk_tc (
        .ents (lk_tc_ents),
        .rid  (lk_rid),
        .va   (lk_va),
        .ps   (PS_W'(PS_MIN)),
        .hit  (lk_tc_hit)
    );

    always_comb begin
        lk_sel = '0;
        if (|lk_tr_hit) begin
            for (int i = NUM_TR - 1; i >= 0; i--) begin
                if (lk_tr_hit[i]) lk_sel = lk_tr_ents[i];
            end
        end else begin
            for (int i = NUM_TC - 1; i >= 0; i--) begin
                if (lk_tc_hit[i]) lk_sel = lk_tc_ents[i];
            end
        end
        lk_hit = lk_sel.vld;
        lk_key = lk_sel.key;
        lk_pa  = lk_sel.vld
                 ? (lk_sel.pa | ({3'b000, lk_addr[60:0]} & ~page_mask64(lk_sel.ps)))
                 : 64'd0;
    end
endmodule

// File: rtl/xlat_pin_chk.sv
module xlat_pin_chk
    import xlat_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cmd_valid,
    input logic                   cmd_ic,
    input logic [1:0]             cmd_cpl,
    input logic                   cmd_nat_slot,
    input logic                   cmd_nat_phys,
    input logic [N_RGN*RID_W-1:0] rgn_ids,
    input logic                   rsp_valid,
    input logic [2:0]             rsp_fault,
    input logic                   lk_side,
    input logic [63:0]            lk_addr,
    input logic                   lk_hit,
    input logic [63:0]            lk_pa,
    input logic [KEY_W-1:0]       lk_key
);
    a_r13_rsp_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> rsp_valid);

    a_r13_no_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !rsp_valid);

    a_r2_illegal_first: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ic) |=> (rsp_fault == 3'd1));

    a_r2_priv_second: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ic && (cmd_cpl != 2'd0)) |=> (rsp_fault == 3'd2));

    a_r2_nat_third: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ic && (cmd_cpl == 2'd0) && (cmd_nat_slot || cmd_nat_phys))
        |=> (rsp_fault == 3'd3));

    a_r3_fault_keeps_table: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_fault != 3'd0) && $stable(lk_addr) && $stable(lk_side)
         && $stable(rgn_ids))
        |-> ($stable(lk_hit) && $stable(lk_pa) && $stable(lk_key)));

    a_r11_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> ((lk_pa == 64'd0) && (lk_key == '0)));

    a_r5_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_pa[11:0] == lk_addr[11:0]));
endmodule

bind xlat_pin_unit xlat_pin_chk u_chk (.*);

// File: tb/sim_xlat_pin_unit.sv
`timescale 1ns/1ps
module sim_xlat_pin_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic         cmd_side = 1'b0;
    logic [7:0]   cmd_slot = '0;
    logic [63:0]  cmd_phys = '0;
    logic [5:0]   cmd_ps = 6'd12;
    logic [23:0]  cmd_key = '0;
    logic [63:0]  cmd_va = '0;
    logic         cmd_ic = 1'b0;
    logic [1:0]   cmd_cpl = '0;
    logic         cmd_vm = 1'b0;
    logic         cmd_nat_slot = 1'b0;
    logic         cmd_nat_phys = 1'b0;
    logic [191:0] rgn_ids;
    logic         lk_side = 1'b0;
    logic [63:0]  lk_addr = '0;
    logic         rsp_valid, rsp_valid1;
    logic [2:0]   rsp_fault, rsp_fault1;
    logic         lk_hit, lk_hit1;
    logic [63:0]  lk_pa, lk_pa1;
    logic [23:0]  lk_key, lk_key1;

    int total = 0;
    int bad = 0;
    logic       got_vld;
    logic [2:0] got_fault;

    always #2 clk = ~clk;

    xlat_pin_unit u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_side(cmd_side),
        .cmd_slot(cmd_slot), .cmd_phys(cmd_phys), .cmd_ps(cmd_ps), .cmd_key(cmd_key),
        .cmd_va(cmd_va), .cmd_ic(cmd_ic), .cmd_cpl(cmd_cpl), .cmd_vm(cmd_vm),
        .cmd_nat_slot(cmd_nat_slot), .cmd_nat_phys(cmd_nat_phys), .rgn_ids(rgn_ids),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .lk_side(lk_side),
        .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_key(lk_key)
    );

    xlat_pin_unit #(.CROSS_PURGE(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_side(cmd_side),
        .cmd_slot(cmd_slot), .cmd_phys(cmd_phys), .cmd_ps(cmd_ps), .cmd_key(cmd_key),
        .cmd_va(cmd_va), .cmd_ic(cmd_ic), .cmd_cpl(cmd_cpl), .cmd_vm(cmd_vm),
        .cmd_nat_slot(cmd_nat_slot), .cmd_nat_phys(cmd_nat_phys), .rgn_ids(rgn_ids),
        .rsp_valid(rsp_valid1), .rsp_fault(rsp_fault1), .lk_side(lk_side),
        .lk_addr(lk_addr), .lk_hit(lk_hit1), .lk_pa(lk_pa1), .lk_key(lk_key1)
    );

    function automatic logic [63:0] vaddr(input logic [2:0] rgn, input logic [60:0] off);
        return {rgn, off};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_rgn_default();
        for (int i = 0; i < 8; i++) rgn_ids[i*24 +: 24] = 24'h100 + 24'(i);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cmd_valid = 1'b0;
        set_rgn_default();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic issue(input logic side, input logic [7:0] slot, input logic [63:0] phys,
                         input logic [5:0] ps, input logic [23:0] key, input logic [63:0] va,
                         input logic ic, input logic [1:0] cpl, input logic vm,
                         input logic ns, input logic np);
        cmd_side = side; cmd_slot = slot; cmd_phys = phys; cmd_ps = ps; cmd_key = key;
        cmd_va = va; cmd_ic = ic; cmd_cpl = cpl; cmd_vm = vm;
        cmd_nat_slot = ns; cmd_nat_phys = np;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        got_vld = rsp_valid;
        got_fault = rsp_fault;
    endtask

    task automatic ins(input logic side, input logic [7:0] slot, input logic [63:0] phys,
                       input logic [5:0] ps, input logic [23:0] key, input logic [63:0] va);
        issue(side, slot, phys, ps, key, va, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic look(input string tag, input bit on_u1, input logic side,
                        input logic [63:0] addr, input logic eh, input logic [63:0] epa,
                        input logic [23:0] ekey);
        logic [88:0] act, exp;
        lk_side = side;
        lk_addr = addr;
        #0.5;
        act = on_u1 ? {lk_hit1, lk_pa1, lk_key1} : {lk_hit, lk_pa, lk_key};
        exp = eh ? {1'b1, epa, ekey} : 89'd0;
        chk(act == exp, tag, 128'(act), 128'(exp));
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R13 watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        // R12: reset state
        do_reset();
        chk(rsp_valid == 1'b0, "R12 rsp_valid after reset", 128'(rsp_valid), 128'd0);
        look("R12 empty instr", 0, 1'b0, vaddr(3'd0, 61'h0), 1'b0, 0, 0);
        look("R12 empty data", 0, 1'b1, vaddr(3'd7, 61'h1234_5000), 1'b0, 0, 0);

        // R2 and R3: all 128 combinations of the seven fault causes
        for (int m = 0; m < 128; m++) begin
            logic [2:0] ef;
            logic [63:0] va_c, va_s, ph;
            ef = 3'd0;
            for (int b = 6; b >= 0; b--) if (m[b]) ef = 3'(b + 1);
            va_c = vaddr(3'd2, 61'h4000_0000 + 61'(m) * 61'h10_0000);
            va_s = va_c;
            if (m[5]) va_s[55] = 1'b1;
            ph = 64'h7_0000_0000 + (64'(m) << 12);
            issue(1'b0, m[3] ? 8'd9 : 8'd2, ph, m[4] ? 6'd13 : 6'd12, 24'(m), va_s,
                  m[0], m[1] ? 2'd3 : 2'd0, m[6], m[2] & m[3], m[2] & ~m[3]);
            chk(got_vld == 1'b1 && got_fault == ef, "R2 fault priority",
                128'({got_vld, got_fault}), 128'({1'b1, ef}));
            look("R3 table after command", 0, 1'b0, va_c, ef == 3'd0, ph, 24'(m));
        end
        // R13: response drops in the following idle cycle
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R13 rsp_valid idle", 128'(rsp_valid), 128'd0);

        // R1: slot boundary; R2: reserved physical bits
        do_reset();
        ins(1'b1, 8'd7, 64'h5000, 6'd12, 24'h7, vaddr(3'd0, 61'h9000));
        chk(got_fault == 3'd0, "R1 slot 7 accepted", 128'(got_fault), 128'd0);
        ins(1'b1, 8'd8, 64'h6000, 6'd12, 24'h8, vaddr(3'd0, 61'hA000));
        chk(got_fault == 3'd4, "R1 slot 8 rejected", 128'(got_fault), 128'd4);
        ins(1'b1, 8'd255, 64'h6000, 6'd12, 24'h8, vaddr(3'd0, 61'hA000));
        chk(got_fault == 3'd4, "R1 slot 255 rejected", 128'(got_fault), 128'd4);
        ins(1'b1, 8'd1, 64'h0004_0000_0000_0000, 6'd12, 24'h9, vaddr(3'd0, 61'hB000));
        chk(got_fault == 3'd5, "R2 physical bit 50", 128'(got_fault), 128'd5);
        ins(1'b1, 8'd1, 64'h0002_0000_0000_0000, 6'd12, 24'h9, vaddr(3'd0, 61'hB000));
        chk(got_fault == 3'd0, "R2 physical bit 49", 128'(got_fault), 128'd0);
        ins(1'b1, 8'd2, 64'hC000, 6'd12, 24'hA, vaddr(3'd0, 61'h0004_0000_0000_C000));
        chk(got_fault == 3'd0, "R2 virtual bit 50", 128'(got_fault), 128'd0);

        // R6: every page-size code
        do_reset();
        for (int p = 0; p < 64; p++) begin
            logic [63:0] base, ph, sz;
            logic legal;
            legal = (p >= 12) && (p <= 26) && (p % 2 == 0);
            base = vaddr(3'd1, 61'(p) * 61'h1000_0000);
            ph = 64'h3_0000_0000 + 64'(p) * 64'h1000_0000;
            sz = 64'd1 << p;
            ins(1'b0, 8'(p % 8), ph, 6'(p), 24'(p), base);
            chk(got_fault == (legal ? 3'd0 : 3'd5), "R6 code legality",
                128'(got_fault), 128'(legal ? 3'd0 : 3'd5));
            if (legal) begin
                look("R6 last byte inside", 0, 1'b0, base + sz - 1, 1'b1, ph + sz - 1, 24'(p));
                look("R6 first byte past", 0, 1'b0, base + sz, 1'b0, 0, 0);
            end else begin
                look("R3 illegal code left nothing", 0, 1'b0, base, 1'b0, 0, 0);
            end
        end

        // R5: alignment of both addresses
        do_reset();
        ins(1'b0, 8'd0, 64'hABCD_1234, 6'd16, 24'h55, vaddr(3'd0, 61'h1234_5678));
        look("R5 aligned base", 0, 1'b0, vaddr(3'd0, 61'h1234_0000), 1'b1, 64'hABCD_0000, 24'h55);
        look("R5 top of page", 0, 1'b0, vaddr(3'd0, 61'h1234_FFFF), 1'b1, 64'hABCD_FFFF, 24'h55);
        look("R5 above page", 0, 1'b0, vaddr(3'd0, 61'h1235_0000), 1'b0, 0, 0);
        look("R5 below page", 0, 1'b0, vaddr(3'd0, 61'h1233_FFFF), 1'b0, 0, 0);

        // R4: region identifiers
        ins(1'b0, 8'd1, 64'h9_0000, 6'd12, 24'h33, vaddr(3'd3, 61'h40_0000));
        look("R4 own region", 0, 1'b0, vaddr(3'd3, 61'h40_0010), 1'b1, 64'h9_0010, 24'h33);
        look("R4 other region", 0, 1'b0, vaddr(3'd5, 61'h40_0010), 1'b0, 0, 0);
        rgn_ids[5*24 +: 24] = 24'h103;
        look("R4 aliased region", 0, 1'b0, vaddr(3'd5, 61'h40_0010), 1'b1, 64'h9_0010, 24'h33);
        rgn_ids[3*24 +: 24] = 24'h777;
        look("R4 changed region", 0, 1'b0, vaddr(3'd3, 61'h40_0010), 1'b0, 0, 0);
        set_rgn_default();

        // R9: rotating placement of displaced entries
        do_reset();
        for (int k = 0; k < 18; k++)
            ins(1'b1, 8'd0, 64'h4_0000_0000 + (64'(k) << 20), 6'd12, 24'(k),
                vaddr(3'd0, 61'(k) << 20));
        look("R9 oldest overwritten", 0, 1'b1, vaddr(3'd0, 61'h0), 1'b0, 0, 0);
        for (int k = 1; k < 18; k++)
            look("R9 displaced kept", 0, 1'b1, vaddr(3'd0, 61'(k) << 20), 1'b1,
                 64'h4_0000_0000 + (64'(k) << 20), 24'(k));
        look("R9 no config effect", 1, 1'b1, vaddr(3'd0, 61'(16) << 20), 1'b1,
             64'h4_0000_0000 + (64'(16) << 20), 24'd16);

        // R10: displaced entry that overlaps its successor is dropped
        do_reset();
        ins(1'b0, 8'd0, 64'h1_0000_0000, 6'd12, 24'hA1, vaddr(3'd0, 61'h50_0000));
        ins(1'b0, 8'd0, 64'h1_1000_0000, 6'd12, 24'hA2, vaddr(3'd0, 61'h50_0000));
        ins(1'b0, 8'd0, 64'h1_2000_0000, 6'd12, 24'hB0, vaddr(3'd0, 61'h90_0000));
        look("R10 first page dropped", 0, 1'b0, vaddr(3'd0, 61'h50_0000), 1'b1,
             64'h1_1000_0000, 24'hA2);

        // R7: same-side purge, small new inside large cached
        do_reset();
        ins(1'b0, 8'd0, 64'h2_0000_0000, 6'd20, 24'hE0, vaddr(3'd0, 61'h100_0000));
        ins(1'b0, 8'd0, 64'h2_1000_0000, 6'd12, 24'hF0, vaddr(3'd0, 61'h900_0000));
        ins(1'b0, 8'd2, 64'h2_2000_0000, 6'd12, 24'h11, vaddr(3'd0, 61'h110_0000));
        look("R7 adjacent page spares", 0, 1'b0, vaddr(3'd0, 61'h100_0000), 1'b1,
             64'h2_0000_0000, 24'hE0);
        ins(1'b0, 8'd1, 64'h2_3000_0000, 6'd12, 24'h22, vaddr(3'd0, 61'h100_5000));
        look("R7 large cached purged", 0, 1'b0, vaddr(3'd0, 61'h100_0000), 1'b0, 0, 0);

        // R7: large new over small cached
        do_reset();
        ins(1'b0, 8'd0, 64'h5_0000_0000, 6'd12, 24'hC1, vaddr(3'd0, 61'h300_3000));
        ins(1'b0, 8'd0, 64'h5_1000_0000, 6'd12, 24'hC2, vaddr(3'd0, 61'h900_0000));
        ins(1'b0, 8'd1, 64'h5_2000_0000, 6'd20, 24'hC3, vaddr(3'd0, 61'h300_0000));
        ins(1'b0, 8'd1, 64'h5_3000_0000, 6'd12, 24'hC4, vaddr(3'd0, 61'hA00_0000));
        look("R7 small cached purged", 0, 1'b0, vaddr(3'd0, 61'h300_3000), 1'b1,
             64'h5_2000_3000, 24'hC3);

        // R8: cross-side purge in both configurations
        do_reset();
        ins(1'b1, 8'd0, 64'h6_0000_0000, 6'd20, 24'hD1, vaddr(3'd0, 61'h200_0000));
        ins(1'b1, 8'd0, 64'h6_1000_0000, 6'd12, 24'hD2, vaddr(3'd0, 61'h800_0000));
        ins(1'b0, 8'd3, 64'h6_2000_0000, 6'd12, 24'hD3, vaddr(3'd0, 61'h200_5000));
        look("R8 cross purge on", 0, 1'b1, vaddr(3'd0, 61'h200_0000), 1'b0, 0, 0);
        look("R8 cross purge off", 1, 1'b1, vaddr(3'd0, 61'h200_0000), 1'b1,
             64'h6_0000_0000, 24'hD1);
        look("R8 pinned data kept", 0, 1'b1, vaddr(3'd0, 61'h800_0000), 1'b1,
             64'h6_1000_0000, 24'hD2);

        // R11: pinned over cached, lowest pinned index
        do_reset();
        ins(1'b0, 8'd1, 64'h8_0000_0000, 6'd12, 24'h01, vaddr(3'd0, 61'h400_2000));
        ins(1'b0, 8'd2, 64'h8_1000_0000, 6'd12, 24'h02, vaddr(3'd0, 61'h400_2000));
        ins(1'b0, 8'd0, 64'h8_2000_0000, 6'd20, 24'h03, vaddr(3'd0, 61'h400_0000));
        ins(1'b0, 8'd0, 64'h8_3000_0000, 6'd12, 24'h04, vaddr(3'd0, 61'hC00_0000));
        look("R11 pinned wins", 0, 1'b0, vaddr(3'd0, 61'h400_2008), 1'b1,
             64'h8_0000_0008, 24'h01);
        look("R11 cached used", 0, 1'b0, vaddr(3'd0, 61'h401_0000), 1'b1,
             64'h8_2001_0000, 24'h03);
        look("R11 miss zeros", 0, 1'b0, vaddr(3'd0, 61'h600_0000), 1'b0, 0, 0);

        finish_run();
    end
endmodule